// File: doc/BRIEF.md
# Vector Widening Unpack Unit

This execution unit takes one 128-bit source vector and widens half of its elements to twice their width, which yields a full 128-bit result. An 8-bit secondary opcode picks one of four variants. The variant fixes which half of the source is read, the upper or the lower, and how each element is extended, with its sign or with zeros. A 4-bit size field gives the source element width. The result element is always one size step wider than the source element.

All four variants use one datapath. Each operation is registered once, so its result or its exception appears exactly one clock after the input strobe. A size code the unit does not support raises a specification exception in place of a result. An opcode byte outside the four variants is ignored.

Top module: `vec_widen_unit`

## Requirements
- R1: Opcode byte 0xD7 selects signed/upper-half, 0xD5 logical/upper-half, 0xD6 signed/lower-half and 0xD4 logical/lower-half.
- R2: Size code 0 widens 8-bit elements to 16 bits, code 1 widens 16 to 32, and code 2 widens 32 to 64. The result holds 128 / (2 x source width) elements.
- R3: Element 0 sits at the most significant end (bits 127 down). In the upper-half variants, result element i comes from source element i, so only source bits 127..64 are used.
- R4: In the lower-half variants, result element i comes from source element i + N, where N is the result element count. Only source bits 63..0 are used.
- R5: The signed variants copy the top bit of each selected element into the new upper bits. The logical variants fill those bits with zeros.
- R6: A recognised opcode with a size code above 2 gives out_spec_exc = 1, out_valid = 0 and out_result = 0 one clock later.
- R7: A strobe with an opcode byte outside the four variants gives out_valid = 0, out_spec_exc = 0 and out_result = 0 one clock later.
- R8: The outputs of an accepted strobe appear exactly one clock later. They are computed only from the source value sampled at that strobe, so a source change after the edge has no effect. Strobes on consecutive cycles each give their own result.
- R9: A synchronous active-low reset clears out_valid, out_spec_exc and out_result at the next clock edge, even while the input strobe is high.
- R10: out_valid and out_spec_exc are never high together. out_result is zero whenever out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| in_opcode | input | 8 | Secondary opcode byte that selects the variant |
| in_size | input | 4 | Source element size code |
| in_src | input | 128 | Source vector, element 0 at the MSB end |
| out_valid | output | 1 | Result strobe, one clock after in_valid |
| out_result | output | 128 | Widened result vector |
| out_spec_exc | output | 1 | Specification exception for an illegal size code |

## Verification
A wrong half-select shows in the very next output word. The result elements then repeat the wrong half of the source, so bench sources whose two halves differ expose it at once. A wrong slice offset or extension mux shows in the same cycle, as a shifted or wrongly filled element in that word. The bench uses edge-case bytes such as 0x80, 0x7F, 0xFF and 0x00 to make these visible. A decode or size-check fault appears in the flags one clock after the strobe, either as a valid result that should have been an exception or as a stray flag on an unknown opcode. A stale value in the output register appears one cycle after an idle or reset cycle, as a nonzero result or a held flag.

// File: rtl/vwu_pkg.sv
package vwu_pkg;

    localparam int VEC_W      = 128;
    localparam int OP_W       = 8;
    localparam int SIZE_W     = 4;
    localparam int NUM_SIZES  = 3;
    localparam int MAX_SIZE   = NUM_SIZES - 1;
    localparam int BASE_ELEM  = 8;

    localparam logic [OP_W-1:0] OPC_SIGN_UPPER  = 8'hD7;
    localparam logic [OP_W-1:0] OPC_LOGIC_UPPER = 8'hD5;
    localparam logic [OP_W-1:0] OPC_SIGN_LOWER  = 8'hD6;
    localparam logic [OP_W-1:0] OPC_LOGIC_LOWER = 8'hD4;

    typedef struct packed {
        logic known;
        logic upper;
        logic zero_fill;
    } vwu_variant_t;

    typedef struct packed {
        logic             valid;
        logic             exc;
        logic [VEC_W-1:0] result;
    } vwu_out_t;

endpackage

// File: rtl/vwu_decode.sv
module vwu_decode
    import vwu_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output vwu_variant_t    variant
);

    always_comb begin
        variant = '0;
        unique case (opcode)
            OPC_SIGN_UPPER: begin
                variant.known     = 1'b1;
                variant.upper     = 1'b1;
                variant.zero_fill = 1'b0;
            end
            OPC_LOGIC_UPPER: begin
                variant.known     = 1'b1;
                variant.upper     = 1'b1;
                variant.zero_fill = 1'b1;
            end
            OPC_SIGN_LOWER: begin
                variant.known     = 1'b1;
                variant.upper     = 1'b0;
                variant.zero_fill = 1'b0;
            end
            OPC_LOGIC_LOWER: begin
                variant.known     = 1'b1;
                variant.upper     = 1'b0;
                variant.zero_fill = 1'b1;
            end
            default: variant = '0;
        endcase
    end

endmodule

// File: rtl/vwu_size_check.sv
module vwu_size_check
    import vwu_pkg::*;
#(
    parameter int MAX_CODE = MAX_SIZE
) (
    input  logic [SIZE_W-1:0] size_code,
    output logic              legal
);

    localparam logic [SIZE_W-1:0] LIMIT = SIZE_W'(MAX_CODE);

    always_comb begin
        legal = (size_code <= LIMIT);
    end

endmodule

// File: rtl/vwu_widen.sv
module vwu_widen #(
    parameter int VEC_W = 128,
    parameter int SRC_W = 8
) (
    input  logic [VEC_W-1:0] src,
    input  logic             upper,
    input  logic             zero_fill,
    output logic [VEC_W-1:0] dst
);

    localparam int DST_W = 2 * SRC_W;
    localparam int N_DST = VEC_W / DST_W;
    localparam int SKIP  = N_DST;

    for (genvar i = 0; i < N_DST; i++) begin : g_lane
        logic [SRC_W-1:0] up_e;
        logic [SRC_W-1:0] lo_e;
        logic [SRC_W-1:0] pick;
        logic             fill;

        always_comb begin
            up_e = src[VEC_W-1-i*SRC_W -: SRC_W];
            lo_e = src[VEC_W-1-(i+SKIP)*SRC_W -: SRC_W];
            pick = upper ? up_e : lo_e;
            fill = zero_fill ? 1'b0 : pick[SRC_W-1];
        end

        assign dst[VEC_W-1-i*DST_W -: DST_W] = {{SRC_W{fill}}, pick};
    end

endmodule

// File: rtl/vec_widen_unit.sv
module vec_widen_unit
    import vwu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   in_opcode,
    input  logic [SIZE_W-1:0] in_size,
    input  logic [VEC_W-1:0]  in_src,
    output logic              out_valid,
    output logic [VEC_W-1:0]  out_result,
    output logic              out_spec_exc
);

    vwu_variant_t     variant;
    logic             size_ok;
    logic [VEC_W-1:0] widened [NUM_SIZES];
    logic [VEC_W-1:0] chosen;
    vwu_out_t         out_d;
    vwu_out_t         out_q;

    vwu_decode u_decode (
        .opcode  (in_opcode),
        .variant (variant)
    );

    vwu_size_check #(.MAX_CODE(MAX_SIZE)) u_size (
        .size_code (in_size),
        .legal     (size_ok)
    );

    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
        vwu_widen #(
            .VEC_W (VEC_W),
            .SRC_W (BASE_ELEM << k)
        ) u_widen (
            .src       (in_src),
            .upper     (variant.upper),
            .zero_fill (variant.zero_fill),
            .dst       (widened[k])
        );
    end

    always_comb begin
        chosen = '0;
        for (int k = 0; k < NUM_SIZES; k++) begin
            if (in_size == SIZE_W'(k)) chosen = widened[k];
        end
    end

    always_comb begin
        out_d = '0;
        if (in_valid && variant.known) begin
            if (size_ok) begin
                out_d.valid  = 1'b1;
                out_d.result = chosen;
            end else begin
                out_d.exc = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_valid    = out_q.valid;
    assign out_spec_exc = out_q.exc;
    assign out_result   = out_q.result;

    AST_VALID_EXC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_spec_exc)); // R10

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_result == '0)); // R10

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid || out_spec_exc) |-> $past(in_valid)); // R8

    AST_EXC_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        out_spec_exc |-> ($past(in_size) > SIZE_W'(MAX_SIZE))); // R6

    AST_VALID_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(in_size) <= SIZE_W'(MAX_SIZE))); // R2

    AST_UNKNOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !variant.known) |=> !(out_valid || out_spec_exc)); // R7

endmodule

// File: tb/vec_widen_unit_test.sv
module vec_widen_unit_test;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [7:0]   op;
        logic [3:0]   size;
        logic [127:0] src;
        logic         exp_v;
        logic         exp_e;
    } row_t;

    localparam logic [127:0] S1 = 128'h80FF_0001_7FFF_FFFE_1234_5678_9ABC_DEF0;
    localparam logic [127:0] S2 = 128'hFEDC_BA98_7654_3210_8000_0000_7FFF_FFFF;
    localparam int NROWS = 18;

    localparam row_t TABLE [NROWS] = '{
        '{8'hD7, 4'd0, S1, 1'b1, 1'b0},
        '{8'hD5, 4'd0, S1, 1'b1, 1'b0},
        '{8'hD6, 4'd0, S1, 1'b1, 1'b0},
        '{8'hD4, 4'd0, S1, 1'b1, 1'b0},
        '{8'hD7, 4'd1, S2, 1'b1, 1'b0},
        '{8'hD5, 4'd1, S2, 1'b1, 1'b0},
        '{8'hD6, 4'd1, S2, 1'b1, 1'b0},
        '{8'hD4, 4'd1, S2, 1'b1, 1'b0},
        '{8'hD7, 4'd2, S2, 1'b1, 1'b0},
        '{8'hD5, 4'd2, S2, 1'b1, 1'b0},
        '{8'hD6, 4'd2, S2, 1'b1, 1'b0},
        '{8'hD4, 4'd2, S1, 1'b1, 1'b0},
        '{8'hD7, 4'd3, S1, 1'b0, 1'b1},
        '{8'hD4, 4'd15, S2, 1'b0, 1'b1},
        '{8'hD8, 4'd0, S1, 1'b0, 1'b0},
        '{8'h00, 4'd5, S2, 1'b0, 1'b0},
        '{8'hD3, 4'd1, S1, 1'b0, 1'b0},
        '{8'hF7, 4'd2, S2, 1'b0, 1'b0}
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [7:0]   in_opcode;
    logic [3:0]   in_size;
    logic [127:0] in_src;
    logic         out_valid;
    logic [127:0] out_result;
    logic         out_spec_exc;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_widen_unit uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_opcode    (in_opcode),
        .in_size      (in_size),
        .in_src       (in_src),
        .out_valid    (out_valid),
        .out_result   (out_result),
        .out_spec_exc (out_spec_exc)
    );

    function automatic logic [127:0] model(logic [7:0] op, logic [3:0] size, logic [127:0] src);
        logic [127:0] res = '0;
        logic [127:0] mask;
        logic [127:0] dmask;
        logic [127:0] e;
        int sw = 8 << size;
        int dw = 2 * sw;
        int n = 128 / dw;
        bit up = (op == 8'hD7) || (op == 8'hD5);
        bit sgn = (op == 8'hD7) || (op == 8'hD6);
        mask  = (128'(1) << sw) - 128'(1);
        dmask = (dw == 128) ? '1 : ((128'(1) << dw) - 128'(1));
        for (int i = 0; i < n; i++) begin
            int idx = up ? i : i + n;
            e = (src >> (128 - (idx + 1) * sw)) & mask;
            if (sgn && e[sw-1]) e = e | (~mask & dmask);
            res = res | (e << (128 - (i + 1) * dw));
        end
        return res;
    endfunction

    task automatic check_out(logic ev, logic ee, logic [127:0] er, string tag);
        checks++;
        if (out_valid !== ev || out_spec_exc !== ee || out_result !== er) begin
            failures++;
            $display("FAIL %s: got v=%0b e=%0b r=%h, expected v=%0b e=%0b r=%h",
                     tag, out_valid, out_spec_exc, out_result, ev, ee, er);
        end
    endtask

    task automatic drive(logic v, logic [7:0] op, logic [3:0] sz, logic [127:0] s);
        in_valid  = v;
        in_opcode = op;
        in_size   = sz;
        in_src    = s;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        drive(1'b1, 8'hD7, 4'd0, S1);
        repeat (3) @(negedge clk);
        check_out(1'b0, 1'b0, '0, "R9 reset state");
        rst_n = 1'b1;

        for (int r = 0; r < NROWS; r++) begin
            string tag;
            logic [127:0] er;
            drive(1'b1, TABLE[r].op, TABLE[r].size, TABLE[r].src);
            @(negedge clk);
            er = TABLE[r].exp_v ? model(TABLE[r].op, TABLE[r].size, TABLE[r].src) : '0;
            if (TABLE[r].exp_e) tag = "R6 illegal size";
            else if (!TABLE[r].exp_v) tag = "R7 unknown opcode";
            else if (TABLE[r].op[0]) tag = "R1 R2 R3 R5 upper";
            else tag = "R1 R2 R4 R5 lower";
            check_out(TABLE[r].exp_v, TABLE[r].exp_e, er, tag);
        end

        drive(1'b0, 8'hD7, 4'd0, S1);
        @(negedge clk);
        check_out(1'b0, 1'b0, '0, "R10 idle output");

        drive(1'b1, 8'hD7, 4'd0, S1);
        @(negedge clk);
        check_out(1'b1, 1'b0, 128'hFF80_FFFF_0000_0001_007F_FFFF_FFFF_FFFE, "R5 signed bytes upper");
        drive(1'b1, 8'hD7, 4'd1, S1);
        @(negedge clk);
        check_out(1'b1, 1'b0, 128'hFFFF80FF_00000001_00007FFF_FFFFFFFE, "R3 signed halves upper");
        drive(1'b1, 8'hD6, 4'd2, S1);
        @(negedge clk);
        check_out(1'b1, 1'b0, 128'h00000000_12345678_FFFFFFFF_9ABCDEF0, "R4 signed words lower");
        drive(1'b1, 8'hD4, 4'd2, S1);
        @(negedge clk);
        check_out(1'b1, 1'b0, 128'h00000000_12345678_00000000_9ABCDEF0, "R5 logical words lower");

        drive(1'b1, 8'hD5, 4'd0, S2);
        @(posedge clk);
        #1;
        drive(1'b0, 8'hD5, 4'd0, ~S2);
        @(negedge clk);
        check_out(1'b1, 1'b0, model(8'hD5, 4'd0, S2), "R8 source sampled at strobe");

        drive(1'b1, 8'hD6, 4'd7, S1);
        @(negedge clk);
        check_out(1'b0, 1'b1, '0, "R6 exception clears result");

        drive(1'b1, 8'hD7, 4'd2, S2);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_out(1'b0, 1'b0, '0, "R9 reset during strobe");
        rst_n = 1'b1;
        drive(1'b0, 8'h00, 4'd0, '0);
        @(negedge clk);
        check_out(1'b0, 1'b0, '0, "R10 idle after reset");

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule